// File: doc/BRIEF.md
# Streaming NAND Page Hamming Code Generator

This block builds a three-byte error-correcting code for one 256-byte chunk of a NAND page while the bytes move between the controller and the flash. There is no buffer and nothing is read back. Each accepted byte updates a set of parity accumulators in the cycle it arrives. When the chunk ends, the code is registered and a done flag is raised.

The code pairs line parity with column parity. Line parity is indexed by the byte's position in the chunk. Column parity is indexed by bit position within the XOR of all bytes. Either of two start strobes opens a chunk and clears the accumulators. One strobe is for the read path and one is for the write path, and both give the same code for the same bytes.

A chunk may be closed early with the finish strobe. The bytes that were not supplied count as erased bytes (0xFF). The padding costs no extra cycles, because a run of 0xFF bytes can only change the column parity, and only through the parity of the number of missing bytes. All parity bits leave the block inverted, so a fully erased chunk gives the code FF FF FF.

Top module: `nandecc_stream`

## Requirements
- R1: After reset, `codeDone` is 0 and `code` is 24'hFFFFFF.
- R2: A pulse on `startRd` or on `startWr` opens a new chunk, clears the accumulators and drops `codeDone` in the next cycle. The same bytes give the same code whichever strobe opened the chunk.
- R3: A byte's address is the number of bytes accepted before it in the chunk, starting at 0. For each address bit k (0..7), `code[2k]` is the inverted XOR of the bit-parities of all bytes whose address bit k is 0. `code[2k+1]` is the same for bytes whose address bit k is 1.
- R4: Let X be the XOR of all 256 bytes. For j = 0..2, `code[16+2j]` is the inverted parity of the bits X[i] whose index i has bit j equal to 0. `code[17+2j]` is the same for indices with bit j equal to 1. `code[23:22]` is always 2'b11.
- R5: A chunk closed after n < 256 bytes yields the code of those bytes followed by 256-n bytes of 0xFF. An all-0xFF chunk and an empty chunk both give 24'hFFFFFF. A single 0x01 byte gives 24'hEAAAAA.
- R6: `codeDone` rises in the cycle after `finish` is sampled during an open chunk, and `code` is valid in that cycle. Both hold until the next start strobe.
- R7: A byte presented in the same cycle as `finish` belongs to the chunk being closed. A byte presented in the same cycle as a start strobe becomes address 0 of the new chunk.
- R8: Bytes beyond the 256th are ignored. Bytes and `finish` presented while no chunk is open change neither `code` nor `codeDone`.
- R9: When a start strobe and `finish` coincide, the start wins: a new chunk opens and `codeDone` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startRd | input | 1 | Open a chunk on the read path |
| startWr | input | 1 | Open a chunk on the write path |
| byteValid | input | 1 | byteData carries a chunk byte this cycle |
| byteData | input | 8 | Data byte |
| finish | input | 1 | Close the chunk and register the code |
| code | output | 24 | Registered code, parity bits inverted |
| codeDone | output | 1 | Code is valid |

## Verification
A byte can arrive in the same cycle as `finish`, and a byte can also share a cycle with a start strobe. In both cases the byte must be folded into the accumulators in the same step as the close or the clear. The bench provokes each collision on purpose, and it also places a start on top of a finish. A behavioural model that keeps the chunk as a plain byte queue judges the result, and `code` and `codeDone` are compared with that model on every clock.

// File: rtl/nandecc_pkg.sv
package nandecc_pkg;
  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic clearAcc;   // open a chunk: accumulators restart
    logic takeByte;   // fold byteData into the accumulators
    logic latchCode;  // register the finished code
    logic padOdd;     // an odd number of 0xFF pad bytes is missing
  } eccCtrl_t;
endpackage

// File: rtl/nandecc_ctrl.sv
module nandecc_ctrl
  import nandecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startRd,
  input  logic              startWr,
  input  logic              byteValid,
  input  logic              finish,
  output eccCtrl_t          ctrl,
  output logic [ADDR_W-1:0] byteAddr,
  output logic              codeDone
);
  localparam logic [ADDR_W:0] CHUNK_N = (ADDR_W+1)'(CHUNK_BYTES);

  logic            active;
  logic [ADDR_W:0] count;
  logic [ADDR_W:0] countAfter;
  logic            anyStart;
  logic            roomLeft;

  assign anyStart = startRd | startWr;
  assign roomLeft = count < CHUNK_N;

  always_comb begin
    ctrl.clearAcc  = anyStart;
    ctrl.takeByte  = byteValid & (anyStart | (active & roomLeft));
    ctrl.latchCode = ~anyStart & active & finish;
    countAfter     = count + {{ADDR_W{1'b0}}, ctrl.takeByte};
    // pad count = CHUNK_N - countAfter; only its parity matters
    ctrl.padOdd    = CHUNK_N[0] ^ countAfter[0];
    byteAddr       = anyStart ? '0 : count[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      count    <= '0;
      codeDone <= 1'b0;
    end else if (anyStart) begin
      active   <= 1'b1;
      count    <= {{ADDR_W{1'b0}}, byteValid};
      codeDone <= 1'b0;
    end else if (ctrl.latchCode) begin
      active   <= 1'b0;
      count    <= countAfter;
      codeDone <= 1'b1;
    end else if (ctrl.takeByte) begin
      count    <= countAfter;
    end
  end
endmodule

// File: rtl/nandecc_datapath.sv
module nandecc_datapath
  import nandecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int COL_W  = 3,
  parameter int CODE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eccCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteData,
  output logic [CODE_W-1:0] code
);
  localparam int COL_BASE = 2 * ADDR_W;

  function automatic logic [DATA_W-1:0] groupMask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = 1'((i >> j) & 1);
    return m;
  endfunction

  logic [ADDR_W-1:0] lineEven, lineOdd;
  logic [DATA_W-1:0] colAcc;
  logic [ADDR_W-1:0] nextEven, nextOdd;
  logic [DATA_W-1:0] nextCol, padCol;
  logic [COL_W-1:0]  colEven, colOdd;
  logic [CODE_W-1:0] codeNext;
  logic              bytePar;

  always_comb begin
    bytePar  = ^byteData;
    nextEven = ctrl.clearAcc ? '0 : lineEven;
    nextOdd  = ctrl.clearAcc ? '0 : lineOdd;
    nextCol  = ctrl.clearAcc ? '0 : colAcc;
    if (ctrl.takeByte) begin
      nextEven = nextEven ^ (~byteAddr & {ADDR_W{bytePar}});
      nextOdd  = nextOdd  ^ ( byteAddr & {ADDR_W{bytePar}});
      nextCol  = nextCol  ^ byteData;
    end
    padCol = nextCol ^ {DATA_W{ctrl.padOdd}};
  end

  for (genvar j = 0; j < COL_W; j++) begin : g_col
    assign colOdd[j]  = ^(padCol &  groupMask(j));
    assign colEven[j] = ^(padCol & ~groupMask(j));
  end

  always_comb begin
    codeNext = '1;
    for (int k = 0; k < ADDR_W; k++) begin
      codeNext[2*k]   = ~nextEven[k];
      codeNext[2*k+1] = ~nextOdd[k];
    end
    for (int j = 0; j < COL_W; j++) begin
      codeNext[COL_BASE+2*j]   = ~colEven[j];
      codeNext[COL_BASE+2*j+1] = ~colOdd[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineEven <= '0;
      lineOdd  <= '0;
      colAcc   <= '0;
      code     <= '1;
    end else begin
      if (ctrl.clearAcc || ctrl.takeByte) begin
        lineEven <= nextEven;
        lineOdd  <= nextOdd;
        colAcc   <= nextCol;
      end
      if (ctrl.latchCode) code <= codeNext;
    end
  end
endmodule

// File: rtl/nandecc_stream.sv
module nandecc_stream
  import nandecc_pkg::*;
#(
  parameter  int CHUNK_BYTES = 256,
  parameter  int DATA_W      = 8,
  localparam int ADDR_W      = $clog2(CHUNK_BYTES),
  localparam int COL_W       = $clog2(DATA_W),
  localparam int CODE_W      = ((2 * (ADDR_W + COL_W) + 7) / 8) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startRd,
  input  logic              startWr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              finish,
  output logic [CODE_W-1:0] code,
  output logic              codeDone
);
  eccCtrl_t          ctrl;
  logic [ADDR_W-1:0] byteAddr;

  nandecc_ctrl #(.CHUNK_BYTES(CHUNK_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startRd(startRd), .startWr(startWr),
    .byteValid(byteValid), .finish(finish), .ctrl(ctrl),
    .byteAddr(byteAddr), .codeDone(codeDone)
  );

  nandecc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_W(COL_W),
                     .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .byteAddr(byteAddr),
    .byteData(byteData), .code(code)
  );
endmodule

// File: rtl/nandecc_chk.sv
module nandecc_chk #(
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startRd,
  input logic              startWr,
  input logic              finish,
  input logic [CODE_W-1:0] code,
  input logic              codeDone
);
  // R6
  done_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codeDone) |-> $past(finish));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (codeDone && !startRd && !startWr) |=> (codeDone && $stable(code)));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startRd || startWr) |=> !codeDone);

  // R8
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!codeDone && !finish) |=> !codeDone);

  // R4
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    codeDone |-> (code[CODE_W-1 -: 2] == 2'b11));
endmodule

bind nandecc_stream nandecc_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startRd(startRd), .startWr(startWr),
  .finish(finish), .code(code), .codeDone(codeDone)
);

// File: tb/nandecc_stream_bench.sv
module nandecc_stream_bench;
  logic clk = 0, rst_n = 0;
  logic startRd = 0, startWr = 0, byteValid = 0, finish = 0;
  logic [7:0] byteData = 0;
  logic [23:0] code;
  logic codeDone;

  int checks = 0, fails = 0;
  string curTag = "R1";
  bit modelOn = 0;

  always #5 clk = ~clk;

  nandecc_stream u_nandecc_stream (
    .clk(clk), .rst_n(rst_n), .startRd(startRd), .startWr(startWr),
    .byteValid(byteValid), .byteData(byteData), .finish(finish),
    .code(code), .codeDone(codeDone)
  );

  // Behavioural model: chunk kept as a byte queue.
  logic [7:0]  chunkQ[$];
  bit          mActive = 0;
  logic [23:0] expCode = 24'hFFFFFF;
  bit          expDone = 0;

  function automatic logic [23:0] refCode(input logic [7:0] q[$]);
    logic [7:0] le = 0, lo = 0, x = 0;
    logic [2:0] ce = 0, co = 0;
    logic [23:0] r;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] b = (a < q.size()) ? q[a] : 8'hFF;
      bit p = ^b;
      for (int k = 0; k < 8; k++)
        if ((a >> k) & 1) lo[k] ^= p; else le[k] ^= p;
      x ^= b;
    end
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        if ((i >> j) & 1) co[j] ^= x[i]; else ce[j] ^= x[i];
    r = 24'hFFFFFF;
    for (int k = 0; k < 8; k++) begin r[2*k] = ~le[k]; r[2*k+1] = ~lo[k]; end
    for (int j = 0; j < 3; j++) begin r[16+2*j] = ~ce[j]; r[17+2*j] = ~co[j]; end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mActive = 0; expDone = 0; expCode = 24'hFFFFFF; chunkQ.delete();
    end else if (startRd || startWr) begin
      mActive = 1; expDone = 0; chunkQ.delete();
      if (byteValid) chunkQ.push_back(byteData);
    end else if (mActive) begin
      if (byteValid && chunkQ.size() < 256) chunkQ.push_back(byteData);
      if (finish) begin
        expCode = refCode(chunkQ); expDone = 1; mActive = 0;
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (modelOn) begin
      checks++;
      if (code !== expCode || codeDone !== expDone) begin
        fails++;
        $display("FAIL %s: code=%h done=%b expected code=%h done=%b",
                 curTag, code, codeDone, expCode, expDone);
      end
    end
  end

  task automatic drive(bit sRd, bit sWr, bit bv, logic [7:0] bd, bit fin);
    @(negedge clk);
    startRd = sRd; startWr = sWr; byteValid = bv; byteData = bd; finish = fin;
  endtask

  task automatic idle();
    drive(0, 0, 0, 8'h00, 0);
  endtask

  task automatic expectCode(string tag, logic [23:0] val, bit dn);
    checks++;
    if (code !== val || codeDone !== dn) begin
      fails++;
      $display("FAIL %s: code=%h done=%b expected code=%h done=%b",
               tag, code, codeDone, val, dn);
    end
  endtask

  logic [23:0] savedCode;

  task automatic runAll();
    repeat (3) @(negedge clk);
    // R1 reset state
    expectCode("R1", 24'hFFFFFF, 0);
    rst_n = 1;
    modelOn = 1;
    idle();

    // R3 incrementing data, write path
    curTag = "R3";
    drive(0, 1, 0, 0, 0);
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 8'(i), 0);
    drive(0, 0, 0, 0, 1); idle();
    savedCode = code;
    expectCode("R6", expCode, 1);
    idle(); idle();
    expectCode("R6", savedCode, 1);

    // R2 same data, read path, same code
    curTag = "R2";
    drive(1, 0, 0, 0, 0);
    idle();
    expectCode("R2", savedCode, 0);
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 8'(i), 0);
    drive(0, 0, 0, 0, 1); idle();
    expectCode("R2", savedCode, 1);

    // R4 pseudo-random full chunk
    curTag = "R4";
    drive(0, 1, 0, 0, 0);
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 8'((i * 37 + 11) ^ (i >> 3)), 0);
    drive(0, 0, 0, 0, 1); idle();
    expectCode("R4", expCode, 1);

    // R5 erased chunk, empty chunk, single 0x01 byte, short chunk
    curTag = "R5";
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 8'hFF, 0);
    drive(0, 0, 0, 0, 1); idle();
    expectCode("R5", 24'hFFFFFF, 1);
    drive(0, 1, 0, 0, 0); drive(0, 0, 0, 0, 1); idle();
    expectCode("R5", 24'hFFFFFF, 1);
    drive(0, 1, 0, 0, 0); drive(0, 0, 1, 8'h01, 0); drive(0, 0, 0, 0, 1); idle();
    expectCode("R5", 24'hEAAAAA, 1);
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) drive(0, 0, 1, 8'(i * 29 + 3), 0);
    drive(0, 0, 0, 0, 1); idle();

    // R7 byte with start, byte with finish
    curTag = "R7";
    drive(0, 1, 1, 8'h5A, 0);
    for (int i = 0; i < 6; i++) drive(0, 0, 1, 8'(i + 100), 0);
    drive(0, 0, 1, 8'hC3, 1); idle();
    expectCode("R7", expCode, 1);

    // R8 overlong chunk, then traffic while closed
    curTag = "R8";
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) drive(0, 0, 1, 8'(i * 7), 0);
    drive(0, 0, 0, 0, 1); idle();
    savedCode = code;
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 8'(i), i == 2);
    idle();
    expectCode("R8", savedCode, 1);

    // R9 start and finish together
    curTag = "R9";
    drive(0, 1, 0, 0, 0); drive(0, 0, 1, 8'h11, 0);
    drive(1, 0, 1, 8'h22, 1); idle();
    expectCode("R9", savedCode, 0);
    drive(0, 0, 0, 0, 1); idle();
    expectCode("R9", expCode, 1);
    idle();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule